// File: doc/BRIEF.md
# Dual-Mode Translation Lookaside Buffer

This block holds completed address translations for a paged memory unit. It keeps two independent arrays, one for user mode and one for supervisor mode. Each array is direct-mapped. The processor side presents a virtual page number, a mode and a read/write flag. One clock later the block answers hit or miss, and on a hit it returns the physical frame number and the read-only, cache-inhibit and modified attributes. A table walker writes fresh translations through a separate fill port.

Entries are never removed by software commands. They are removed as a side effect of traffic on a register bus that the block watches:

- A full-word read of the buffer-control register drops both arrays.
- Specific full-word write values to that register drop one array.
- Any write to a root-pointer register drops the array of its mode.
- A full-word write of zero in the purge address space drops the entry for that address in both arrays.

Valid bits live in flops, so a whole-array drop takes one clock.

Top module: `xlat_buf_dual`

## Requirements
- R1: After reset `rsp_vld` is low, and every lookup misses until a fill is made.
- R2: A lookup presented in cycle t is answered in cycle t+1. The answer has `rsp_vld` high, and on a hit it carries the frame, read-only, cache-inhibit and modified values of the last fill of that entry. User and supervisor entries are separate: a fill in one mode never hits in the other.
- R3: Each array has 1024 entries. The array is indexed by virtual address bits 21:12 and tagged with bits 31:22. A lookup to the same index with a different tag misses. A later fill to that index replaces the older entry.
- R4: A write lookup that matches an entry whose modified flag is 0 is answered as a miss. A read lookup to that entry hits, and a write lookup to an entry with modified 1 hits.
- R5: A full-word read (fc not 3) of the register at base+0x8 invalidates every entry of both arrays. A lookup in the very next cycle already misses.
- R6: A full-word write of 0x00000000 to base+0x8 invalidates only the user array. A full-word write of 0x00008000 invalidates only the supervisor array. Any other value, and any half-word access to that register, leaves both arrays unchanged.
- R7: Register accesses decode as follows:
  - A write to base+0x4 (user root) invalidates the user array.
  - A write to base+0x0 (supervisor root) invalidates the supervisor array.
  - A write to base+0xC changes nothing.
  - Full-word accesses must have address bits 1:0 equal to 0, and half-word accesses must have bit 0 equal to 0.
- R8: A full-word write of data 0 with function code 3 invalidates, in both arrays, the entry whose index and tag match the write address. Entries with other indices or tags survive. Nonzero data has no effect.
- R9: When a fill and an invalidation hit the same entry in the same cycle, the invalidation wins and the entry stays invalid. A fill that the same-cycle invalidation does not target still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_sup | input | 1 | Lookup mode, 1 = supervisor |
| lk_wr | input | 1 | Lookup is for a write |
| lk_vpn | input | 20 | Virtual page number (VA bits 31:12) |
| rsp_vld | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | 20 | Physical frame number on hit |
| rsp_ro | output | 1 | Read-only attribute |
| rsp_ci | output | 1 | Cache-inhibit attribute |
| rsp_mod | output | 1 | Modified attribute |
| fill_en | input | 1 | Fill from the table walker |
| fill_sup | input | 1 | Fill mode, 1 = supervisor |
| fill_vpn | input | 20 | Virtual page number being filled |
| fill_pfn | input | 20 | Frame number being filled |
| fill_ro | input | 1 | Read-only attribute to store |
| fill_ci | input | 1 | Cache-inhibit attribute to store |
| fill_mod | input | 1 | Modified attribute to store |
| bus_en | input | 1 | Register-bus access strobe |
| bus_wr | input | 1 | Access is a write |
| bus_long | input | 1 | Full-word (1) or half-word (0) access |
| bus_fc | input | 3 | Function code of the access |
| bus_addr | input | 32 | Access address |
| bus_wdata | input | 32 | Write data |

## Verification
Two events can land in the same cycle: a fill from the walker and an invalidation decoded from the register bus. The bench drives both strobes on one clock edge in three combinations:

- a full flush together with a fill,
- a purge of exactly the address being filled,
- a purge of a different address together with a fill.

The next lookup to each filled address must miss in the first two cases and hit in the third. A further case pairs a one-mode flush with a fill in the other mode, and that fill must survive.

// File: rtl/xlat_buf_pkg.sv
`timescale 1ns/1ps
package xlat_buf_pkg;
    localparam int VA_W  = 32;
    localparam int PG_W  = 12;
    localparam int IDX_W = 10;
    localparam int PFN_W = 20;
    localparam int VPN_W = VA_W - PG_W;
    localparam int TAG_W = VPN_W - IDX_W;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             ro;
        logic             ci;
        logic             md;
    } xb_attr_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        xb_attr_t         attr;
    } xb_ent_t;
endpackage

// File: rtl/xlat_buf_bank.sv
`timescale 1ns/1ps
module xlat_buf_bank
    import xlat_buf_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int TW = TAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] lk_idx,
    input  logic [TW-1:0] lk_tag,
    output logic          lk_match,
    output xb_attr_t      lk_attr,
    input  logic          flush,
    input  logic          pg_en,
    input  logic [IW-1:0] pg_idx,
    input  logic [TW-1:0] pg_tag,
    input  logic          fl_en,
    input  logic [IW-1:0] fl_idx,
    input  logic [TW-1:0] fl_tag,
    input  xb_attr_t      fl_attr
);
    localparam int DEPTH = 1 << IW;

    logic [DEPTH-1:0] vld;
    xb_ent_t          mem [DEPTH];
    logic             fill_blk;
    logic             pg_hit;

    assign fill_blk = pg_en && (pg_idx == fl_idx) && (pg_tag == fl_tag);
    assign pg_hit   = pg_en && vld[pg_idx] && (mem[pg_idx].tag == pg_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (flush) begin
            vld <= '0;
        end else begin
            if (pg_hit)
                vld[pg_idx] <= 1'b0;
            if (fl_en && !fill_blk)
                vld[fl_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fl_en && !flush && !fill_blk)
            mem[fl_idx] <= '{tag: fl_tag, attr: fl_attr};
    end

    assign lk_match = vld[lk_idx] && (mem[lk_idx].tag == lk_tag);
    assign lk_attr  = mem[lk_idx].attr;

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld == '0)); // R5

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && !flush && !fill_blk) |=> vld[$past(fl_idx)]); // R2

    AST_FILL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && fill_blk && !$past(fl_en && fl_idx == pg_idx) && !vld[fl_idx])
        |=> !vld[$past(fl_idx)]); // R9
endmodule

// File: rtl/xlat_buf_regdec.sv
`timescale 1ns/1ps
module xlat_buf_regdec
    import xlat_buf_pkg::*;
#(
    parameter logic [VA_W-1:0] REG_BASE = 32'h0040_0000,
    parameter logic [2:0]      PURGE_FC = 3'd3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_wr,
    input  logic            bus_long,
    input  logic [2:0]      bus_fc,
    input  logic [VA_W-1:0] bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic            flush_usr,
    output logic            flush_sup,
    output logic            purge_en
);
    localparam logic [31:0] SUP_ONLY = 32'h0000_8000;

    typedef enum logic [1:0] {
        OFF_SROOT = 2'd0,
        OFF_UROOT = 2'd1,
        OFF_CTRL  = 2'd2,
        OFF_STAT  = 2'd3
    } reg_off_e;

    logic     purge_space, aligned, reg_sel;
    reg_off_e off;
    logic     ctl_rd, ctl_wu, ctl_ws, root_u, root_s;

    assign purge_space = (bus_fc == PURGE_FC);
    assign aligned     = !bus_addr[0] && !(bus_long && bus_addr[1]);
    assign reg_sel     = bus_en && !purge_space && aligned &&
                         (bus_addr[VA_W-1:4] == REG_BASE[VA_W-1:4]);
    assign off         = reg_off_e'(bus_addr[3:2]);

    always_comb begin
        ctl_rd = 1'b0;
        ctl_wu = 1'b0;
        ctl_ws = 1'b0;
        root_u = 1'b0;
        root_s = 1'b0;
        if (reg_sel) begin
            unique case (off)
                OFF_SROOT: root_s = bus_wr;
                OFF_UROOT: root_u = bus_wr;
                OFF_CTRL: begin
                    ctl_rd = !bus_wr && bus_long;
                    ctl_wu = bus_wr && bus_long && (bus_wdata == '0);
                    ctl_ws = bus_wr && bus_long && (bus_wdata == SUP_ONLY);
                end
                OFF_STAT: ;
            endcase
        end
    end

    assign flush_usr = ctl_rd || ctl_wu || root_u;
    assign flush_sup = ctl_rd || ctl_ws || root_s;
    assign purge_en  = bus_en && bus_wr && bus_long && purge_space &&
                       (bus_wdata == '0);

    AST_BOTH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_usr && flush_sup) |-> !bus_wr); // R5

    AST_PURGE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        purge_en |-> !(flush_usr || flush_sup)); // R8
endmodule

// File: rtl/xlat_buf_dual.sv
`timescale 1ns/1ps
module xlat_buf_dual
    import xlat_buf_pkg::*;
#(
    parameter logic [VA_W-1:0] REG_BASE = 32'h0040_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_en,
    input  logic             lk_sup,
    input  logic             lk_wr,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             rsp_vld,
    output logic             rsp_hit,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic             rsp_ro,
    output logic             rsp_ci,
    output logic             rsp_mod,
    input  logic             fill_en,
    input  logic             fill_sup,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_ro,
    input  logic             fill_ci,
    input  logic             fill_mod,
    input  logic             bus_en,
    input  logic             bus_wr,
    input  logic             bus_long,
    input  logic [2:0]       bus_fc,
    input  logic [VA_W-1:0]  bus_addr,
    input  logic [31:0]      bus_wdata
);
    localparam int NMODE = 2;

    logic     flush_usr, flush_sup, purge_en;
    logic     hit_c [NMODE];
    xb_attr_t attr_c [NMODE];
    xb_attr_t fill_attr;
    xb_attr_t sel_attr;
    logic     sel_hit;
    logic     rsp_wr_q;

    assign fill_attr = '{pfn: fill_pfn, ro: fill_ro, ci: fill_ci, md: fill_mod};

    xlat_buf_regdec #(.REG_BASE(REG_BASE)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_long  (bus_long),
        .bus_fc    (bus_fc),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flush_usr (flush_usr),
        .flush_sup (flush_sup),
        .purge_en  (purge_en)
    );

    for (genvar g = 0; g < NMODE; g++) begin : g_bank
        xlat_buf_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_idx   (lk_vpn[IDX_W-1:0]),
            .lk_tag   (lk_vpn[VPN_W-1:IDX_W]),
            .lk_match (hit_c[g]),
            .lk_attr  (attr_c[g]),
            .flush    ((g == 1) ? flush_sup : flush_usr),
            .pg_en    (purge_en),
            .pg_idx   (bus_addr[PG_W+IDX_W-1:PG_W]),
            .pg_tag   (bus_addr[VA_W-1:PG_W+IDX_W]),
            .fl_en    (fill_en && (fill_sup == (g == 1))),
            .fl_idx   (fill_vpn[IDX_W-1:0]),
            .fl_tag   (fill_vpn[VPN_W-1:IDX_W]),
            .fl_attr  (fill_attr)
        );
    end

    assign sel_hit  = lk_sup ? hit_c[1]  : hit_c[0];
    assign sel_attr = lk_sup ? attr_c[1] : attr_c[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            rsp_hit  <= 1'b0;
            rsp_wr_q <= 1'b0;
            rsp_pfn  <= '0;
            rsp_ro   <= 1'b0;
            rsp_ci   <= 1'b0;
            rsp_mod  <= 1'b0;
        end else begin
            rsp_vld  <= lk_en;
            rsp_hit  <= lk_en && sel_hit && (!lk_wr || sel_attr.md);
            rsp_wr_q <= lk_wr;
            if (lk_en) begin
                rsp_pfn <= sel_attr.pfn;
                rsp_ro  <= sel_attr.ro;
                rsp_ci  <= sel_attr.ci;
                rsp_mod <= sel_attr.md;
            end
        end
    end

    AST_WR_NEEDS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_wr_q) |-> rsp_mod); // R4

    AST_HIT_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_vld && $past(lk_en))); // R2
endmodule

// File: tb/xlat_buf_dual_tb.sv
`timescale 1ns/1ps
module xlat_buf_dual_tb;
    localparam logic [31:0] BASE = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_en = 0, lk_sup = 0, lk_wr = 0;
    logic [19:0] lk_vpn = '0;
    logic        rsp_vld, rsp_hit, rsp_ro, rsp_ci, rsp_mod;
    logic [19:0] rsp_pfn;
    logic        fill_en = 0, fill_sup = 0, fill_ro = 0, fill_ci = 0, fill_mod = 0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic        bus_en = 0, bus_wr = 0, bus_long = 0;
    logic [2:0]  bus_fc = 3'd1;
    logic [31:0] bus_addr = '0, bus_wdata = '0;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    typedef struct {
        bit          hit;
        logic [19:0] pfn;
        bit          ro, ci, md;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    xlat_buf_dual #(.REG_BASE(BASE)) u_dut (.*);

    // monitor: pops one expected item per answer
    always @(negedge clk) begin
        if (rst_n && rsp_vld) begin
            nvec++;
            if (q.size() == 0) begin
                nbad++;
                $display("FAIL unexpected answer: act hit=%0b exp none", rsp_hit);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rsp_hit !== e.hit) begin
                    nbad++;
                    $display("FAIL %s: act hit=%0b exp hit=%0b", e.tag, rsp_hit, e.hit);
                end else if (e.hit && {rsp_pfn, rsp_ro, rsp_ci, rsp_mod} !==
                                      {e.pfn, e.ro, e.ci, e.md}) begin
                    nbad++;
                    $display("FAIL %s: act pfn=%h ro%0b ci%0b md%0b exp pfn=%h ro%0b ci%0b md%0b",
                             e.tag, rsp_pfn, rsp_ro, rsp_ci, rsp_mod,
                             e.pfn, e.ro, e.ci, e.md);
                end
            end
        end
    end

    task automatic look(input bit sup, input logic [31:0] va, input bit wr,
                        input bit hit, input logic [19:0] pfn,
                        input bit ro, input bit ci, input bit md, input string tag);
        exp_t e;
        e.hit = hit; e.pfn = pfn; e.ro = ro; e.ci = ci; e.md = md; e.tag = tag;
        q.push_back(e);
        lk_en = 1; lk_sup = sup; lk_wr = wr; lk_vpn = va[31:12];
        @(negedge clk);
        lk_en = 0;
    endtask

    task automatic miss(input bit sup, input logic [31:0] va, input bit wr, input string tag);
        look(sup, va, wr, 0, '0, 0, 0, 0, tag);
    endtask

    task automatic put_fill(input bit sup, input logic [31:0] va, input logic [19:0] pfn,
                            input bit ro, input bit ci, input bit md);
        fill_en = 1; fill_sup = sup; fill_vpn = va[31:12]; fill_pfn = pfn;
        fill_ro = ro; fill_ci = ci; fill_mod = md;
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic acc(input bit wr, input bit lng, input logic [2:0] fc,
                       input logic [31:0] addr, input logic [31:0] data);
        bus_en = 1; bus_wr = wr; bus_long = lng; bus_fc = fc;
        bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_en = 0;
    endtask

    localparam logic [31:0] VA_A = 32'h0000_5000; // idx 5, tag 0
    localparam logic [31:0] VA_B = 32'h0040_5000; // idx 5, tag 1
    localparam logic [31:0] VA_C = 32'h1230_7000; // idx 0x307
    localparam logic [31:0] VA_D = 32'hFFFF_F000; // idx 0x3FF

    initial begin
        repeat (3) @(negedge clk);
        nvec++;
        if (rsp_vld !== 1'b0) begin
            nbad++;
            $display("FAIL R1 reset: act rsp_vld=%0b exp 0", rsp_vld);
        end
        rst_n = 1;
        @(negedge clk);
        miss(0, VA_A, 0, "R1 empty after reset");

        // R2 basic fill and separate modes
        put_fill(0, VA_A, 20'hABCDE, 0, 1, 1);
        look(0, VA_A, 0, 1, 20'hABCDE, 0, 1, 1, "R2 user hit");
        miss(1, VA_A, 0, "R2 other mode miss");
        // R3 index and tag
        miss(0, VA_B, 0, "R3 tag mismatch");
        look(0, VA_A + 32'hFFC, 0, 1, 20'hABCDE, 0, 1, 1, "R3 offset ignored");
        // R4 modified flag
        put_fill(1, VA_D, 20'h11111, 1, 0, 0);
        look(1, VA_D, 0, 1, 20'h11111, 1, 0, 0, "R4 read clean hit");
        miss(1, VA_D, 1, "R4 write clean miss");
        put_fill(0, VA_C, 20'h22222, 0, 0, 1);
        look(0, VA_C, 1, 1, 20'h22222, 0, 0, 1, "R4 write dirty hit");
        put_fill(0, VA_B, 20'h33333, 0, 0, 1);
        miss(0, VA_A, 0, "R3 replaced");
        look(0, VA_B, 0, 1, 20'h33333, 0, 0, 1, "R3 new tag hit");

        // R6 control-register write values
        acc(1, 1, 3'd1, BASE + 8, 32'h0000_8000);
        miss(1, VA_D, 0, "R6 sup flushed");
        look(0, VA_C, 0, 1, 20'h22222, 0, 0, 1, "R6 user kept");
        acc(1, 0, 3'd1, BASE + 8, 32'h0);
        look(0, VA_C, 0, 1, 20'h22222, 0, 0, 1, "R6 half-word no effect");
        acc(1, 1, 3'd1, BASE + 8, 32'h1234);
        look(0, VA_C, 0, 1, 20'h22222, 0, 0, 1, "R6 other value no effect");
        put_fill(1, VA_D, 20'h11111, 1, 0, 0);
        acc(1, 1, 3'd1, BASE + 8, 32'h0);
        miss(0, VA_C, 0, "R6 user flushed");
        miss(0, VA_B, 0, "R6 user flushed 2");
        look(1, VA_D, 0, 1, 20'h11111, 1, 0, 0, "R6 sup kept");

        // R7 root pointers and status
        put_fill(0, VA_C, 20'h22222, 0, 0, 1);
        acc(1, 1, 3'd1, BASE + 32'hC, 32'h0);
        look(0, VA_C, 0, 1, 20'h22222, 0, 0, 1, "R7 status no effect");
        look(1, VA_D, 0, 1, 20'h11111, 1, 0, 0, "R7 status no effect sup");
        acc(1, 1, 3'd1, BASE + 4, 32'h0000_0123);
        miss(0, VA_C, 0, "R7 user root flush");
        look(1, VA_D, 0, 1, 20'h11111, 1, 0, 0, "R7 sup kept");
        acc(1, 0, 3'd5, BASE + 2, 32'h0000_0077);
        miss(1, VA_D, 0, "R7 sup root flush");

        // R5 full flush, one-cycle
        put_fill(0, VA_C, 20'h22222, 0, 0, 1);
        put_fill(1, VA_D, 20'h11111, 1, 0, 0);
        acc(0, 1, 3'd1, BASE + 8, 32'h0);
        miss(0, VA_C, 0, "R5 user gone next cycle");
        miss(1, VA_D, 0, "R5 sup gone");

        // R8 purge space
        put_fill(0, VA_A, 20'h44444, 0, 0, 1);
        put_fill(1, VA_A, 20'h55555, 0, 0, 1);
        put_fill(0, VA_C, 20'h22222, 0, 0, 1);
        acc(1, 1, 3'd3, VA_A, 32'h0);
        miss(0, VA_A, 0, "R8 user purged");
        miss(1, VA_A, 0, "R8 sup purged");
        look(0, VA_C, 0, 1, 20'h22222, 0, 0, 1, "R8 other index kept");
        acc(1, 1, 3'd3, VA_C, 32'h1);
        look(0, VA_C, 0, 1, 20'h22222, 0, 0, 1, "R8 nonzero data no effect");
        put_fill(0, VA_A, 20'h44444, 0, 0, 1);
        acc(1, 1, 3'd3, VA_B, 32'h0);
        look(0, VA_A, 0, 1, 20'h44444, 0, 0, 1, "R8 other tag kept");

        // R9 same-cycle fill and invalidation
        fill_en = 1; fill_sup = 0; fill_vpn = VA_D[31:12]; fill_pfn = 20'h66666;
        fill_ro = 0; fill_ci = 0; fill_mod = 1;
        bus_en = 1; bus_wr = 0; bus_long = 1; bus_fc = 3'd1; bus_addr = BASE + 8;
        @(negedge clk);
        fill_en = 0; bus_en = 0;
        miss(0, VA_D, 0, "R9 flush beats fill");

        fill_en = 1; fill_sup = 1; fill_vpn = VA_C[31:12]; fill_pfn = 20'h77777;
        bus_en = 1; bus_wr = 1; bus_long = 1; bus_fc = 3'd3; bus_addr = VA_C; bus_wdata = 0;
        @(negedge clk);
        fill_en = 0; bus_en = 0;
        miss(1, VA_C, 0, "R9 purge beats fill");

        fill_en = 1; fill_sup = 0; fill_vpn = VA_D[31:12]; fill_pfn = 20'h66666;
        bus_en = 1; bus_wr = 1; bus_long = 1; bus_fc = 3'd3; bus_addr = VA_A; bus_wdata = 0;
        @(negedge clk);
        fill_en = 0; bus_en = 0;
        look(0, VA_D, 0, 1, 20'h66666, 0, 0, 1, "R9 untargeted fill lands");

        fill_en = 1; fill_sup = 1; fill_vpn = VA_D[31:12]; fill_pfn = 20'h12345;
        fill_ro = 1; fill_mod = 1;
        bus_en = 1; bus_wr = 1; bus_long = 1; bus_fc = 3'd1; bus_addr = BASE + 8; bus_wdata = 0;
        @(negedge clk);
        fill_en = 0; bus_en = 0;
        look(1, VA_D, 0, 1, 20'h12345, 1, 0, 1, "R9 other-mode fill survives");
        miss(0, VA_D, 0, "R9 user flushed alongside");

        repeat (3) @(negedge clk);
        nvec++;
        if (q.size() != 0) begin
            nbad++;
            $display("FAIL R2 answers missing: act left=%0d exp 0", q.size());
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                nbad++;
                $display("FAIL watchdog: act timeout exp completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule